// File: doc/BRIEF.md
# Registered Bidirectional Bus Transceiver

This block sits between two parallel buses, called A and B, and moves data in one direction at a time. Each side has its own capture register. The register for the A side samples the A bus on the rising edge of its own clock. The register for the B side samples the B bus on the rising edge of a second clock. Capture takes place on every such edge, whatever the enable and direction controls are set to.

The output side is controlled by an active-low enable and a direction bit. Together they decide which bus, if either, is driven. For the driven bus, a select line picks one of two sources:
- the live value on the opposite bus, which passes straight through with no register in the path;
- the value held in the opposite side's capture register.

Bus pins are modelled as separate input vectors, output vectors and output-enable flags, so a pad ring or bus fabric can form the three-state drivers outside this block. A parameter can make both data paths inverting. The data carried has no flow control, so the edges of this block are plain level signals rather than valid/ready handshakes.

Top module: `bus_xcvr_reg`

## Requirements
- R1: On every rising edge of `clk_ab` with `rst` low, the A-side register loads `a_in`. This happens whatever the levels of `en_n` and `dir`.
- R2: On every rising edge of `clk_ba` with `rst` low, the B-side register loads `b_in`. This happens whatever the levels of `en_n` and `dir`.
- R3: A rising edge of either clock with `rst` high clears that clock's register to all zeros.
- R4: While `en_n` is 1, `a_oe` and `b_oe` are both 0, and `a_out` and `b_out` are both all zeros.
- R5: While `en_n` is 0 and `dir` is 1, `b_oe` is 1, `a_oe` is 0 and `a_out` is all zeros.
- R6: While `en_n` is 0 and `dir` is 0, `a_oe` is 1, `b_oe` is 0 and `b_out` is all zeros.
- R7: When `b_oe` is 1 and `sel_ab` is 0, `b_out` follows `a_in` combinationally, in the same cycle.
- R8: When `b_oe` is 1 and `sel_ab` is 1, `b_out` shows the A-side register and does not follow later changes on `a_in`.
- R9: When `a_oe` is 1, `a_out` shows `b_in` live if `sel_ba` is 0, and shows the B-side register if `sel_ba` is 1.
- R10: In stored mode, a capture edge on the driving side puts the newly captured value on the driven bus right after that edge.
- R11: With `INVERT` set to 1, both the live and the stored sources appear complemented on the outputs. The registers still hold the true bus value, so a stored output equals the bitwise NOT of the captured word.
- R12: The select line of the direction that is not active (`sel_ba` while `dir` is 1, `sel_ab` while `dir` is 0) has no effect on any output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_ab | input | 1 | Capture clock for the A-side register (rising edge) |
| clk_ba | input | 1 | Capture clock for the B-side register (rising edge) |
| rst | input | 1 | Synchronous clear, active high, sampled on each capture clock |
| en_n | input | 1 | Output enable, active low |
| dir | input | 1 | 1 = drive B from the A side, 0 = drive A from the B side |
| sel_ab | input | 1 | Source for B: 0 = live A, 1 = A-side register |
| sel_ba | input | 1 | Source for A: 0 = live B, 1 = B-side register |
| a_in | input | WIDTH | Value sensed on bus A |
| b_in | input | WIDTH | Value sensed on bus B |
| a_out | output | WIDTH | Value driven onto bus A when `a_oe` is 1, zero otherwise |
| a_oe | output | 1 | Drive enable for bus A |
| b_out | output | WIDTH | Value driven onto bus B when `b_oe` is 1, zero otherwise |
| b_oe | output | 1 | Drive enable for bus B |

## Verification
The capture assertions assume that each capture clock is a clean pulse. They also assume that `a_in`, `b_in` and `rst` are stable around the rising edge, so the value seen at the edge is the value the register stores. The stimulus meets this by changing every input only while both capture clocks are low, and by raising a capture clock only after the inputs have settled for a full cycle of the bench clock. The output assertions check each case whenever a select or an input changes, with no extra assumption. Every control combination is driven on two instances at once, one non-inverting and one inverting, and both are compared against a reference model kept in the bench.

// File: rtl/bxr_pkg.sv
package bxr_pkg;
  typedef enum logic [1:0] {
    ROUTE_NONE = 2'd0,
    ROUTE_TO_B = 2'd1,
    ROUTE_TO_A = 2'd2
  } route_e;
endpackage

// File: rtl/bxr_dirctl.sv
module bxr_dirctl
  import bxr_pkg::*;
(
  input  logic   en_n,
  input  logic   dir,
  output route_e route,
  output logic   a_oe,
  output logic   b_oe
);
  always_comb begin
    if (en_n)     route = ROUTE_NONE;
    else if (dir) route = ROUTE_TO_B;
    else          route = ROUTE_TO_A;
  end

  assign a_oe = (route == ROUTE_TO_A);
  assign b_oe = (route == ROUTE_TO_B);
endmodule

// File: rtl/bxr_capture.sv
module bxr_capture #(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  always_ff @(posedge clk) begin
    if (rst) q <= '0;
    else     q <= d;
  end
endmodule

// File: rtl/bxr_outmux.sv
module bxr_outmux #(
  parameter int WIDTH  = 8,
  parameter bit INVERT = 1'b0
) (
  input  logic [WIDTH-1:0] live,
  input  logic [WIDTH-1:0] stored,
  input  logic             sel,
  input  logic             oe,
  output logic [WIDTH-1:0] out
);
  logic [WIDTH-1:0] picked;
  logic [WIDTH-1:0] shaped;

  assign picked = sel ? stored : live;

  generate
    if (INVERT) begin : g_inv
      assign shaped = ~picked;
    end else begin : g_pass
      assign shaped = picked;
    end
  endgenerate

  assign out = oe ? shaped : '0;
endmodule

// File: rtl/bus_xcvr_reg.sv
module bus_xcvr_reg
  import bxr_pkg::*;
#(
  parameter int WIDTH  = 8,
  parameter bit INVERT = 1'b0
) (
  input  logic             clk_ab,
  input  logic             clk_ba,
  input  logic             rst,
  input  logic             en_n,
  input  logic             dir,
  input  logic             sel_ab,
  input  logic             sel_ba,
  input  logic [WIDTH-1:0] a_in,
  input  logic [WIDTH-1:0] b_in,
  output logic [WIDTH-1:0] a_out,
  output logic             a_oe,
  output logic [WIDTH-1:0] b_out,
  output logic             b_oe
);
  route_e           route;
  logic [WIDTH-1:0] a_q;
  logic [WIDTH-1:0] b_q;

  bxr_dirctl u_dirctl (
    .en_n  (en_n),
    .dir   (dir),
    .route (route),
    .a_oe  (a_oe),
    .b_oe  (b_oe)
  );

  bxr_capture #(.WIDTH(WIDTH)) u_cap_a (
    .clk (clk_ab),
    .rst (rst),
    .d   (a_in),
    .q   (a_q)
  );

  bxr_capture #(.WIDTH(WIDTH)) u_cap_b (
    .clk (clk_ba),
    .rst (rst),
    .d   (b_in),
    .q   (b_q)
  );

  bxr_outmux #(.WIDTH(WIDTH), .INVERT(INVERT)) u_mux_to_b (
    .live   (a_in),
    .stored (a_q),
    .sel    (sel_ab),
    .oe     (b_oe),
    .out    (b_out)
  );

  bxr_outmux #(.WIDTH(WIDTH), .INVERT(INVERT)) u_mux_to_a (
    .live   (b_in),
    .stored (b_q),
    .sel    (sel_ba),
    .oe     (a_oe),
    .out    (a_out)
  );
endmodule

// File: rtl/bxr_chk.sv
module bxr_chk #(
  parameter int WIDTH  = 8,
  parameter bit INVERT = 1'b0
) (
  input logic             clk_ab,
  input logic             clk_ba,
  input logic             rst,
  input logic             en_n,
  input logic             dir,
  input logic             sel_ab,
  input logic             sel_ba,
  input logic [WIDTH-1:0] a_in,
  input logic [WIDTH-1:0] b_in,
  input logic [WIDTH-1:0] a_out,
  input logic             a_oe,
  input logic [WIDTH-1:0] b_out,
  input logic             b_oe,
  input logic [WIDTH-1:0] a_q,
  input logic [WIDTH-1:0] b_q
);
  localparam logic [WIDTH-1:0] MASK = INVERT ? {WIDTH{1'b1}} : '0;

  // R1
  a_capture_chk: assert property (@(posedge clk_ab) disable iff (rst)
    !rst |=> a_q == $past(a_in));

  // R2
  b_capture_chk: assert property (@(posedge clk_ba) disable iff (rst)
    !rst |=> b_q == $past(b_in));

  always_comb begin
    // R4
    isolate_chk: assert (!en_n || (!a_oe && !b_oe && a_out == '0 && b_out == '0));
    // R5
    to_b_en_chk: assert (en_n || !dir || (b_oe && !a_oe && a_out == '0));
    // R6
    to_a_en_chk: assert (en_n || dir || (a_oe && !b_oe && b_out == '0));
    // R7
    b_live_chk: assert (!b_oe || sel_ab || b_out == (a_in ^ MASK));
    // R8
    b_stored_chk: assert (!b_oe || !sel_ab || b_out == (a_q ^ MASK));
    // R9
    a_src_chk: assert (!a_oe || a_out == ((sel_ba ? b_q : b_in) ^ MASK));
  end
endmodule

bind bus_xcvr_reg bxr_chk #(.WIDTH(WIDTH), .INVERT(INVERT)) u_chk (
  .clk_ab (clk_ab),
  .clk_ba (clk_ba),
  .rst    (rst),
  .en_n   (en_n),
  .dir    (dir),
  .sel_ab (sel_ab),
  .sel_ba (sel_ba),
  .a_in   (a_in),
  .b_in   (b_in),
  .a_out  (a_out),
  .a_oe   (a_oe),
  .b_out  (b_out),
  .b_oe   (b_oe),
  .a_q    (a_q),
  .b_q    (b_q)
);

// File: tb/bus_xcvr_reg_test.sv
module bus_xcvr_reg_test;
  localparam int W = 8;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic clk_ab = 1'b0, clk_ba = 1'b0, rst = 1'b0;
  logic en_n = 1'b1, dir = 1'b0, sel_ab = 1'b0, sel_ba = 1'b0;
  logic [W-1:0] a_in = '0, b_in = '0;
  logic [W-1:0] a_out, b_out, ia_out, ib_out;
  logic a_oe, b_oe, ia_oe, ib_oe;

  int checks = 0;
  int fails  = 0;
  int cycles = 0;
  bit done   = 1'b0;

  logic [W-1:0] ra = '0, rb = '0;

  bus_xcvr_reg #(.WIDTH(W), .INVERT(1'b0)) uut (
    .clk_ab(clk_ab), .clk_ba(clk_ba), .rst(rst), .en_n(en_n), .dir(dir),
    .sel_ab(sel_ab), .sel_ba(sel_ba), .a_in(a_in), .b_in(b_in),
    .a_out(a_out), .a_oe(a_oe), .b_out(b_out), .b_oe(b_oe));

  bus_xcvr_reg #(.WIDTH(W), .INVERT(1'b1)) uut_inv (
    .clk_ab(clk_ab), .clk_ba(clk_ba), .rst(rst), .en_n(en_n), .dir(dir),
    .sel_ab(sel_ab), .sel_ba(sel_ba), .a_in(a_in), .b_in(b_in),
    .a_out(ia_out), .a_oe(ia_oe), .b_out(ib_out), .b_oe(ib_oe));

  task automatic chk(input string req, input string what,
                     input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  // Compare every output of both instances with the reference model.
  task automatic check_all(input string req);
    logic eb, ea;
    logic [W-1:0] vb, va;
    #1;
    eb = !en_n && dir;
    ea = !en_n && !dir;
    vb = sel_ab ? ra : a_in;
    va = sel_ba ? rb : b_in;
    chk(req, "b_oe", {{(W-1){1'b0}}, b_oe}, {{(W-1){1'b0}}, eb});
    chk(req, "a_oe", {{(W-1){1'b0}}, a_oe}, {{(W-1){1'b0}}, ea});
    chk(req, "b_out", b_out, eb ? vb : '0);
    chk(req, "a_out", a_out, ea ? va : '0);
    // R11 inverting instance
    chk({req, "/R11"}, "inv b_oe", {{(W-1){1'b0}}, ib_oe}, {{(W-1){1'b0}}, eb});
    chk({req, "/R11"}, "inv a_oe", {{(W-1){1'b0}}, ia_oe}, {{(W-1){1'b0}}, ea});
    chk({req, "/R11"}, "inv b_out", ib_out, eb ? ~vb : '0);
    chk({req, "/R11"}, "inv a_out", ia_out, ea ? ~va : '0);
  endtask

  task automatic pulse_ab();
    @(negedge clk); clk_ab = 1'b1;
    ra = rst ? '0 : a_in;
    @(negedge clk); clk_ab = 1'b0;
  endtask

  task automatic pulse_ba();
    @(negedge clk); clk_ba = 1'b1;
    rb = rst ? '0 : b_in;
    @(negedge clk); clk_ba = 1'b0;
  endtask

  task automatic t_reset();
    a_in = 8'hFF; b_in = 8'hEE; rst = 1'b1;
    @(negedge clk);
    pulse_ab(); pulse_ba();
    @(negedge clk); rst = 1'b0;
    en_n = 1'b1; check_all("R4 reset");
    en_n = 1'b0; dir = 1'b1; sel_ab = 1'b1; check_all("R3 A reg cleared");
    dir = 1'b0; sel_ba = 1'b1; check_all("R3 B reg cleared");
  endtask

  task automatic t_isolation_capture();
    en_n = 1'b1; a_in = 8'h5A; b_in = 8'hC3;
    @(negedge clk);
    pulse_ab(); pulse_ba(); check_all("R4 isolated");
    a_in = 8'h11; b_in = 8'h22;
    @(negedge clk);
    en_n = 1'b0; dir = 1'b1; sel_ab = 1'b1; check_all("R1 captured while isolated");
    dir = 1'b0; sel_ba = 1'b1; check_all("R2 captured while isolated");
  endtask

  task automatic t_live_ab();
    en_n = 1'b0; dir = 1'b1; sel_ab = 1'b0;
    a_in = 8'h00; check_all("R5 R7 live zero");
    a_in = 8'hA5; check_all("R7 live A5");
    a_in = 8'hFF; check_all("R7 live FF");
    a_in = 8'h80; check_all("R7 live 80");
  endtask

  task automatic t_live_ba();
    en_n = 1'b0; dir = 1'b0; sel_ba = 1'b0;
    b_in = 8'h3C; check_all("R6 R9 live 3C");
    b_in = 8'h01; check_all("R9 live 01");
    b_in = 8'hF0; check_all("R9 live F0");
  endtask

  task automatic t_stored_ab();
    en_n = 1'b0; dir = 1'b1; sel_ab = 1'b1;
    a_in = 8'h96;
    @(negedge clk);
    pulse_ab(); check_all("R10 clock in and out A");
    a_in = 8'h69; check_all("R8 stored holds");
    a_in = 8'h0F; check_all("R8 stored holds again");
    @(negedge clk);
    pulse_ab(); check_all("R10 second capture A");
    en_n = 1'b1; a_in = 8'h77;
    @(negedge clk);
    pulse_ab(); check_all("R1 isolated capture");
    en_n = 1'b0; check_all("R8 shows isolated capture");
  endtask

  task automatic t_stored_ba();
    en_n = 1'b0; dir = 1'b0; sel_ba = 1'b1;
    b_in = 8'hB4;
    @(negedge clk);
    pulse_ba(); check_all("R10 clock in and out B");
    b_in = 8'h4B; check_all("R9 stored holds");
    dir = 1'b1; b_in = 8'hD2;
    @(negedge clk);
    pulse_ba(); check_all("R2 capture while B is output side");
    dir = 1'b0; check_all("R9 stored after other-direction capture");
  endtask

  task automatic t_inactive_sel();
    logic [W-1:0] held;
    en_n = 1'b0; dir = 1'b1; sel_ab = 1'b0; a_in = 8'h5C;
    #1 held = b_out;
    sel_ba = ~sel_ba; check_all("R12 sel_ba ignored");
    chk("R12", "b_out unchanged", b_out, held);
    sel_ba = ~sel_ba; check_all("R12 sel_ba ignored back");
    dir = 1'b0; sel_ba = 1'b0; b_in = 8'hE7;
    #1 held = a_out;
    sel_ab = ~sel_ab; check_all("R12 sel_ab ignored");
    chk("R12", "a_out unchanged", a_out, held);
  endtask

  initial begin
    @(negedge clk);
    t_reset();
    t_isolation_capture();
    t_live_ab();
    t_live_ba();
    t_stored_ab();
    t_stored_ba();
    t_inactive_sel();
    done = 1'b1;
  end

  always @(posedge clk) begin
    cycles <= cycles + 1;
  end

  initial begin
    wait (done || cycles >= 100000);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
    end
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule